// File: doc/BRIEF.md
# Vector Load Lane Distributor

This block sits between the on-chip vector buffer read port and the vector register file. It takes one buffer line (256 bytes by default), reshapes its bytes according to a 4-bit distribution code, and presents the result as a full register value. The output appears one clock after the input strobe, with a matching valid strobe.

The reshaping covers several cases: a straight copy, a broadcast of the first element, duplication of each element, keeping one element out of every two, zero-extension to double width, even/odd separation of 32-bit elements, and extraction of the first channel from interleaved 2-channel or 4-channel data. Each case is built once for every element width it supports, and a selector picks one result. A code that names no operation returns zeros and raises an error strobe for that one output cycle. Address generation, buffer arbitration and arithmetic are left to neighbouring blocks.

Top module: `vld_distrib`

## Requirements
- R1: Element k of width W bytes occupies bytes [k*W, k*W+W-1] of the line and of the register, with byte b at bits [8b+7:8b]. Code 0 copies the line to the register unchanged.
- R2: Codes 1, 2 and 3 (8-, 16- and 32-bit elements) put element 0 of the line into every element of the register.
- R3: Codes 4 (8-bit) and 5 (16-bit) set register element k to line element k/2 (rounded down), so only the low half of the line is used.
- R4: Codes 6 (8-bit) and 7 (16-bit) set register element k to line element 2k for k below half the element count, and zero the upper half of the register.
- R5: Codes 8, 9 and 10 (source widths 8, 16 and 32 bits) zero-extend line element k into double-width register element k, taken from the low half of the line.
- R6: Code 11 (32-bit) places the even line elements, in order, in the low half of the register and the odd line elements, in order, in the high half.
- R7: Codes 12 (8-bit) and 13 (16-bit) pick channel 0 of 2-channel interleaved data (the even elements), packed at the bottom of the register, with the upper half zeroed.
- R8: Code 14 sets register byte k to line byte 4k for k below a quarter of the line, and zeroes the remaining bytes.
- R9: Code 15 is undefined. It produces an all-zero register and raises the error output together with the valid output, for that one cycle only. Defined codes never raise it.
- R10: The output valid rises exactly one clock after an input valid and is low otherwise.
- R11: While the input valid is low, the register output keeps its last value, and no change on the line or code inputs reaches it.
- R12: After reset, the output valid and error are low and the register output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Line and code are presented this cycle |
| in_mode | input | 4 | Distribution code |
| in_line | input | LINE_BYTES*8 | Line read from the vector buffer |
| out_valid | output | 1 | Register value is valid |
| out_vreg | output | LINE_BYTES*8 | Reshaped register value |
| out_err | output | 1 | Undefined code was presented |

## Verification
The bench builds the block with LINE_BYTES set to 16. At that size every output byte of every code can be compared for several distinct line patterns. The bench sweeps all sixteen codes, including the undefined one, across four byte patterns, and checks each result byte by byte against an index-arithmetic model. At this width the boundaries between a kept half and a zeroed half, and between the even and odd halves, are only a few bytes apart, so an error in an index or a boundary changes the whole compared vector.

// File: rtl/vld_pkg.sv
package vld_pkg;
   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      M_PASS    = 4'd0,
      M_BC8     = 4'd1,
      M_BC16    = 4'd2,
      M_BC32    = 4'd3,
      M_DUP8    = 4'd4,
      M_DUP16   = 4'd5,
      M_DEC8    = 4'd6,
      M_DEC16   = 4'd7,
      M_WID8    = 4'd8,
      M_WID16   = 4'd9,
      M_WID32   = 4'd10,
      M_EO32    = 4'd11,
      M_CH2_8   = 4'd12,
      M_CH2_16  = 4'd13,
      M_CH4_8   = 4'd14,
      M_BAD     = 4'd15
   } vld_mode_e;
endpackage

// File: rtl/vld_bcast.sv
module vld_bcast #(
   parameter int LB = 256,
   parameter int EB = 1
) (
   input  logic [LB*8-1:0] src,
   output logic [LB*8-1:0] dst
);
   localparam int NE = LB / EB;
   localparam int EW = EB * 8;

   initial begin
      if (LB % EB != 0) $error("vld_bcast: element size must divide line");
   end

   for (genvar k = 0; k < NE; k++) begin : g_lane
      assign dst[k*EW +: EW] = src[0 +: EW];
   end
endmodule

// File: rtl/vld_expand.sv
module vld_expand #(
   parameter int LB = 256,
   parameter int EB = 1
) (
   input  logic [LB*8-1:0] src,
   output logic [LB*8-1:0] dst
);
   localparam int NE = LB / EB;
   localparam int EW = EB * 8;

   initial begin
      if (NE % 2 != 0) $error("vld_expand: element count must be even");
   end

   for (genvar k = 0; k < NE; k++) begin : g_lane
      assign dst[k*EW +: EW] = src[(k/2)*EW +: EW];
   end
endmodule

// File: rtl/vld_decimate.sv
module vld_decimate #(
   parameter int LB     = 256,
   parameter int EB     = 1,
   parameter int STRIDE = 2,
   parameter int PHASE  = 0
) (
   input  logic [LB*8-1:0] src,
   output logic [LB*8-1:0] dst
);
   localparam int NE   = LB / EB;
   localparam int EW   = EB * 8;
   localparam int KEEP = NE / STRIDE;

   initial begin
      if (PHASE >= STRIDE) $error("vld_decimate: phase out of range");
      if (NE % STRIDE != 0) $error("vld_decimate: stride must divide count");
   end

   for (genvar k = 0; k < NE; k++) begin : g_lane
      if (k < KEEP) begin : g_keep
         assign dst[k*EW +: EW] = src[(k*STRIDE+PHASE)*EW +: EW];
      end else begin : g_zero
         assign dst[k*EW +: EW] = '0;
      end
   end
endmodule

// File: rtl/vld_widen.sv
module vld_widen #(
   parameter int LB = 256,
   parameter int EB = 1
) (
   input  logic [LB*8-1:0] src,
   output logic [LB*8-1:0] dst
);
   localparam int EW  = EB * 8;
   localparam int NO  = LB / (2*EB);

   for (genvar k = 0; k < NO; k++) begin : g_lane
      assign dst[k*2*EW +: 2*EW] = {{EW{1'b0}}, src[k*EW +: EW]};
   end
endmodule

// File: rtl/vld_distrib.sv
module vld_distrib
   import vld_pkg::*;
#(
   parameter int LINE_BYTES = 256
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [3:0]              in_mode,
   input  logic [LINE_BYTES*8-1:0] in_line,
   output logic                    out_valid,
   output logic [LINE_BYTES*8-1:0] out_vreg,
   output logic                    out_err
);
   localparam int LB   = LINE_BYTES;
   localparam int LW   = LB * 8;
   localparam int HALF = LW / 2;

   if (LB < 8 || (LB & (LB - 1)) != 0) begin : g_bad_cfg
      initial $error("vld_distrib: LINE_BYTES must be a power of two of at least 8");
   end

   // Candidate results per width: index 0 = 8-bit, 1 = 16-bit, 2 = 32-bit
   logic [LW-1:0] r_bc  [3];
   logic [LW-1:0] r_wid [3];
   logic [LW-1:0] r_dup [2];
   logic [LW-1:0] r_dec [2];
   logic [LW-1:0] r_ev32, r_od32, r_q8;

   for (genvar i = 0; i < 3; i++) begin : g_w3
      vld_bcast #(.LB(LB), .EB(1 << i)) u_bc  (.src(in_line), .dst(r_bc[i]));
      vld_widen #(.LB(LB), .EB(1 << i)) u_wid (.src(in_line), .dst(r_wid[i]));
   end

   for (genvar i = 0; i < 2; i++) begin : g_w2
      vld_expand   #(.LB(LB), .EB(1 << i)) u_dup (.src(in_line), .dst(r_dup[i]));
      vld_decimate #(.LB(LB), .EB(1 << i), .STRIDE(2), .PHASE(0))
         u_dec (.src(in_line), .dst(r_dec[i]));
   end

   vld_decimate #(.LB(LB), .EB(4), .STRIDE(2), .PHASE(0)) u_ev (.src(in_line), .dst(r_ev32));
   vld_decimate #(.LB(LB), .EB(4), .STRIDE(2), .PHASE(1)) u_od (.src(in_line), .dst(r_od32));
   vld_decimate #(.LB(LB), .EB(1), .STRIDE(4), .PHASE(0)) u_q8 (.src(in_line), .dst(r_q8));

   vld_mode_e     mode;
   logic [LW-1:0] nxt_vreg;
   logic          nxt_err;

   assign mode = vld_mode_e'(in_mode);

   always_comb begin
      nxt_err  = 1'b0;
      nxt_vreg = '0;
      unique case (mode)
         M_PASS:   nxt_vreg = in_line;
         M_BC8:    nxt_vreg = r_bc[0];
         M_BC16:   nxt_vreg = r_bc[1];
         M_BC32:   nxt_vreg = r_bc[2];
         M_DUP8:   nxt_vreg = r_dup[0];
         M_DUP16:  nxt_vreg = r_dup[1];
         M_DEC8,
         M_CH2_8:  nxt_vreg = r_dec[0];
         M_DEC16,
         M_CH2_16: nxt_vreg = r_dec[1];
         M_WID8:   nxt_vreg = r_wid[0];
         M_WID16:  nxt_vreg = r_wid[1];
         M_WID32:  nxt_vreg = r_wid[2];
         M_EO32:   nxt_vreg = {r_od32[HALF-1:0], r_ev32[HALF-1:0]};
         M_CH4_8:  nxt_vreg = r_q8;
         default:  nxt_err  = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_vreg  <= '0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid & nxt_err;
         if (in_valid) out_vreg <= nxt_vreg;
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                          // R10
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                        // R10
   AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == M_BAD) |=> (out_err && out_vreg == '0));  // R9
   AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);                                           // R9
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_vreg));                                 // R11
endmodule

// File: tb/vld_distrib_bench.sv
module vld_distrib_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LB = 16;
   localparam int LW = LB * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [3:0]    in_mode = '0;
   logic [LW-1:0] in_line = '0;
   logic          out_valid;
   logic [LW-1:0] out_vreg;
   logic          out_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vld_distrib #(.LINE_BYTES(LB)) u_vld_distrib (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_line(in_line), .out_valid(out_valid), .out_vreg(out_vreg), .out_err(out_err)
   );

   function automatic string req_of(int m);
      case (m)
         0: return "R1";
         1, 2, 3: return "R2";
         4, 5: return "R3";
         6, 7: return "R4";
         8, 9, 10: return "R5";
         11: return "R6";
         12, 13: return "R7";
         14: return "R8";
         default: return "R9";
      endcase
   endfunction

   // Returns the source byte index for output byte ob, or -1 for zero
   function automatic int src_byte(int m, int ob);
      int w, k, b, ne;
      w = 1;
      case (m)
         0: return ob;
         1, 2, 3: begin w = 1 << (m - 1); return ob % w; end
         4, 5: begin w = 1 << (m - 4); k = ob / w; b = ob % w; return (k/2)*w + b; end
         6, 7, 12, 13: begin
            w = (m == 6 || m == 12) ? 1 : 2;
            k = ob / w; b = ob % w; ne = LB / w;
            return (k < ne/2) ? (2*k)*w + b : -1;
         end
         8, 9, 10: begin
            w = 1 << (m - 8); k = ob / (2*w); b = ob % (2*w);
            return (b < w) ? k*w + b : -1;
         end
         11: begin
            ne = LB / 4; k = ob / 4; b = ob % 4;
            return (k < ne/2) ? (2*k)*4 + b : (2*(k - ne/2) + 1)*4 + b;
         end
         14: return (ob < LB/4) ? 4*ob : -1;
         default: return -1;
      endcase
   endfunction

   function automatic logic [LW-1:0] model(int m, logic [LW-1:0] s);
      logic [LW-1:0] o;
      o = '0;
      for (int ob = 0; ob < LB; ob++) begin
         int sb;
         sb = src_byte(m, ob);
         if (sb >= 0) o[ob*8 +: 8] = s[sb*8 +: 8];
      end
      return o;
   endfunction

   function automatic logic [LW-1:0] pattern(int seed);
      logic [LW-1:0] p;
      for (int i = 0; i < LB; i++) p[i*8 +: 8] = 8'((i*37 + seed*91 + 1) ^ (seed*13));
      return p;
   endfunction

   task automatic check(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(int m, logic [LW-1:0] line);
      logic [LW-1:0] held;
      @(negedge clk);
      in_valid = 1'b1; in_mode = 4'(m); in_line = line;
      @(negedge clk);
      in_valid = 1'b0;
      check(req_of(m), $sformatf("data mode %0d", m), out_vreg, model(m, line));
      check("R10", "valid after strobe", LW'(out_valid), LW'(1));
      check("R9", $sformatf("err mode %0d", m), LW'(out_err), LW'(m == 15));
      held = out_vreg;
      in_line = ~line; in_mode = 4'(m ^ 1);
      @(negedge clk);
      check("R11", "hold while idle", out_vreg, held);
      check("R10", "valid low when idle", LW'(out_valid), LW'(0));
      check("R9", "err one cycle only", LW'(out_err), LW'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R12", "reset data", out_vreg, '0);
      check("R12", "reset valid", LW'(out_valid), LW'(0));
      check("R12", "reset err", LW'(out_err), LW'(0));
      rst_n = 1'b1;
      for (int s = 0; s < 4; s++) begin
         for (int m = 0; m < 16; m++) apply(m, pattern(s));
      end
      // Back-to-back strobes: second result must follow the first immediately (R10)
      @(negedge clk);
      in_valid = 1'b1; in_mode = 4'd3; in_line = pattern(7);
      @(negedge clk);
      in_mode = 4'd11; in_line = pattern(8);
      check("R2", "back-to-back first", out_vreg, model(3, pattern(7)));
      @(negedge clk);
      in_valid = 1'b0;
      check("R6", "back-to-back second", out_vreg, model(11, pattern(8)));
      check("R10", "back-to-back valid", LW'(out_valid), LW'(1));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule